// File: doc/BRIEF.md
# Split-Half 64-Bit Cycle Counter

This block keeps a 64-bit count of clock cycles for a 32-bit processor. Software reaches the count as two separate 32-bit registers, a low half and a high half, through a simple register port: one write strobe, one half-select bit shared by reads and writes, a write data word and a read data word. A one-bit inhibit input, driven from bit 0 of the processor's counter-inhibit register, stops the count without blocking writes.

The block's main job is to fix what happens when software writes one half while the count is running. A write replaces only the half it targets, at the clock edge that ends the writing cycle, and takes the place of that half's own update. The other half goes on as if no write had happened. So a carry produced by the old low value still reaches the high half when the low half is overwritten. When the high half is written, the carry out of the low half is lost.

Top module: `split_cycle_counter`

## Requirements
- R1: A synchronous active-high reset sets both halves to zero.
- R2: With inhibit low and no write, the 64-bit value {high, low} rises by exactly one on every rising clock edge.
- R3: rd_data is combinational and shows the current register contents of the low half when sel is 0, or of the high half when sel is 1, with no look-ahead to the next value.
- R4: A write with sel 0 loads wr_data into the low half at the next edge, in place of its increment. Writing zero and reading in the next cycle gives 0, and the cycle after gives 1.
- R5: When a write with sel 0 occurs while the low half is all-ones and inhibit is low, the high half still rises by one at that edge. Repeating this each cycle raises the high half by one per cycle.
- R6: A write with sel 1 loads wr_data into the high half. The low half still counts at that edge, and any carry out of it is dropped.
- R7: When both halves are all-ones and inhibit is low, the next edge wraps both halves to zero.
- R8: While inhibit is high, neither half changes except by a write. Writes still load, so writing zero and then reading twice gives 0 both times.
- R9: After inhibit returns low, counting resumes at one per clock. Eight idle cycles after a write of zero give a low-half read of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inhibit | input | 1 | Stops counting while high |
| wr_en | input | 1 | Write strobe for the half chosen by sel |
| sel | input | 1 | Half select: 0 low, 1 high |
| wr_data | input | 32 | Value to load into the selected half |
| rd_data | output | 32 | Current value of the selected half |

## Verification
The hardest case to reach from the ports is a write that coincides with a carry between the halves. For the low half, that means overwriting it while it already holds all-ones, so the high half must still take the carry. For the high half, the low half is all-ones while the high half is written, so the carry must be dropped. The stimulus gets there by first writing the low half to all-ones, or to one below it, and then issuing the second write in the very next cycle. It also chains several such writes back to back, so that the high half climbs by one per cycle and then both halves wrap from all-ones. A reference model updated on every clock follows each of these steps. A long random run with a biased mix of writes, all-ones data and inhibit toggles checks the same rules in further combinations.

// File: rtl/split_cycle_counter.sv
module split_cycle_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inhibit,
  input  logic         wr_en,
  input  logic         sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] lo_q, hi_q;
  logic         inc, lo_full, carry, wr_lo, wr_hi;

  assign inc     = ~inhibit;
  assign lo_full = &lo_q;
  assign carry   = inc & lo_full;
  assign wr_lo   = wr_en & ~sel;
  assign wr_hi   = wr_en & sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= wr_lo ? wr_data : lo_q + W'(inc);
      hi_q <= wr_hi ? wr_data : hi_q + W'(carry);
    end
  end

  assign rd_data = sel ? hi_q : lo_q;
endmodule

module split_cycle_counter_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         inhibit,
  input logic         wr_en,
  input logic         sel,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] lo,
  input logic [W-1:0] hi
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (lo == '0 && hi == '0)); // R1
  AST_COUNT_ONE: assert property (@(posedge clk) disable iff (rst)
    (!inhibit && !wr_en) |=> {hi, lo} == $past({hi, lo}) + 64'd1); // R2
  AST_READ_MUX: assert property (@(posedge clk) disable iff (rst)
    rd_data == (sel ? hi : lo)); // R3
  AST_LO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel) |=> lo == $past(wr_data)); // R4
  AST_LO_WRITE_CARRY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel && !inhibit && &lo) |=> hi == $past(hi) + 1'b1); // R5
  AST_HI_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel) |=> (hi == $past(wr_data) && lo == $past(lo) + W'(!$past(inhibit)))); // R6
  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!inhibit && !wr_en && &lo && &hi) |=> (lo == '0 && hi == '0)); // R7
  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !wr_en) |=> ($stable(lo) && $stable(hi))); // R8
endmodule

bind split_cycle_counter split_cycle_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .inhibit(inhibit), .wr_en(wr_en), .sel(sel),
  .wr_data(wr_data), .rd_data(rd_data), .lo(lo_q), .hi(hi_q)
);

// File: tb/split_cycle_counter_bench.sv
module split_cycle_counter_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic        inhibit = 0;
  logic        wr_en = 0;
  logic        sel = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  longint unsigned model = 0;

  always #4 clk = ~clk;

  split_cycle_counter u_split_cycle_counter (
    .clk(clk), .rst(rst), .inhibit(inhibit), .wr_en(wr_en), .sel(sel),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // One clock: drive inputs, compare the read port with the model (and with a
  // directed value when given), then let the edge happen and update the model.
  task automatic step(input bit w, input bit s, input logic [31:0] d,
                      input bit has_exp, input logic [31:0] exp, input string tag);
    wr_en = w; sel = s; wr_data = d;
    #1;
    check({tag, " model"}, rd_data, s ? model[63:32] : model[31:0]);
    if (has_exp) check(tag, rd_data, exp);
    @(posedge clk);
    if (rst) model = 0;
    else begin
      if (!inhibit) model = model + 1;
      if (w && s) model[63:32] = d;
      if (w && !s) model[31:0] = d;
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, "R1");
    rst = 0;
    step(0, 0, 0, 0, 0, "R1");
    check("R1 lo after reset", rd_data, 32'd1);
    // R4: write zero, read 0 then 1
    step(1, 0, 32'd0, 0, 0, "R4");
    step(0, 0, 0, 1, 32'd0, "R4 first read");
    step(0, 0, 0, 1, 32'd1, "R4 second read");
    // R5: repeated carry into high half
    step(1, 1, 32'd0, 0, 0, "R5");
    step(1, 0, 32'd0, 0, 0, "R5");
    for (int i = 0; i < 5; i++) step(1, 0, 32'hFFFF_FFFF, 0, 0, "R5");
    step(0, 1, 0, 1, 32'd4, "R5 hi after carries");
    step(0, 1, 0, 1, 32'd5, "R5 hi after wrap of lo");
    step(0, 0, 0, 1, 32'd1, "R5 lo");
    // R7: full wrap
    step(1, 1, 32'd0, 0, 0, "R7");
    step(1, 0, 32'hFFFF_FFFE, 0, 0, "R7");
    step(1, 1, 32'hFFFF_FFFF, 0, 0, "R7");
    step(0, 1, 0, 1, 32'hFFFF_FFFF, "R7 hi all-ones");
    step(0, 1, 0, 1, 32'd0, "R7 hi wrapped");
    step(0, 0, 0, 1, 32'd1, "R7 lo wrapped");
    // R6: high write drops low carry
    step(1, 0, 32'hFFFF_FFFF, 0, 0, "R6");
    step(1, 1, 32'd7, 0, 0, "R6");
    step(0, 1, 0, 1, 32'd7, "R6 hi keeps written value");
    step(0, 0, 0, 1, 32'd1, "R6 lo kept counting");
    // R8: inhibit holds, writes land
    inhibit = 1;
    step(1, 0, 32'd0, 0, 0, "R8");
    step(0, 0, 0, 1, 32'd0, "R8 first read");
    step(0, 0, 0, 1, 32'd0, "R8 second read");
    step(1, 0, 32'hFFFF_FFFF, 0, 0, "R8");
    step(0, 1, 0, 1, 32'd7, "R8 no carry while inhibited");
    step(1, 1, 32'd9, 0, 0, "R8");
    step(0, 0, 0, 1, 32'hFFFF_FFFF, "R8 lo held during hi write");
    step(0, 1, 0, 1, 32'd9, "R8 hi write landed");
    // R9: resume counting
    inhibit = 0;
    step(1, 0, 32'd0, 0, 0, "R9");
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0, 0, "R9");
    step(0, 0, 0, 1, 32'd8, "R9 eight cycles");
    // R2/R3: random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      int r;
      r = $urandom_range(0, 9);
      d = ($urandom_range(0, 2) == 0) ? 32'hFFFF_FFFF : $urandom;
      inhibit = ($urandom_range(0, 7) == 0);
      step(r < 3, $urandom_range(0, 1), d, 0, 0, "R2 R3 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule